// File: doc/BRIEF.md
# Serial Debug Link Controller

This block is the target-side protocol engine of a byte-wide serial debug link between a host and a small processor core. The UART that handles start, data and stop bits sits outside it. Each byte from the UART carries eight data bits, least significant bit first, between one start bit and one full stop bit. The UART presents received bytes to this block as single-cycle strobes and takes transmit bytes through a valid/ready pair. The block decodes command marks and builds multi-byte data words, most significant byte first. It runs a program-load command that writes a raw image into program memory while the core is held in reset. It also runs a start command that leaves reset alone, and a debug-word exchange in both directions. An acknowledge byte answers each completed command.

Inbound debug words go into a one-word mailbox that the core reads. The core hands outbound words to the block, which sends them as a debug mark followed by the word bytes and then waits for the host's acknowledge. Stray bytes between frames, such as the zero bytes a host sends to resynchronise, are skipped. A frame that stalls for a set number of bit times is abandoned.

Top module: `dbg_link_ctrl`

## Requirements
- R1: An inbound word is `NB` bytes, most significant first. Only the low `DW` bits are kept, and the upper bits of the top byte are discarded.
- R2: Mark 0x33 is followed by an address word and a length word. After the length word the block sends one acknowledge byte (`ACK_MARK`, default 0xC3). It also pulses `core_start` for one cycle with `core_start_addr` equal to the address. `core_rst` does not change.
- R3: Mark 0xCC sets `core_rst` to 1 and is followed by an address word and a length word. The next `length` bytes are each written through `pmem_we`/`pmem_addr`/`pmem_wdata`, starting at the address and rising by one per byte.
- R4: A load ends after its last image byte, or straight after the length word when the length is zero. At that point the block sends one acknowledge byte. In the same cycle it drops `core_rst` and raises `core_start` with the load address.
- R5: Mark `DBG_MARK` (default 0x3C) followed by one word stores that word in the mailbox. It sets `mbx_full` and sends one acknowledge byte. `mbx_rd` clears `mbx_full`.
- R6: A debug frame that completes while `mbx_full` is 1 gets no acknowledge and leaves `mbx_data` unchanged.
- R7: A word taken from the core (`core_tx_valid` and `core_tx_ready` both 1) goes out as `DBG_MARK` followed by `NB` bytes, most significant first and zero-extended. `core_tx_ready` then stays 0 until an `ACK_MARK` byte arrives between frames.
- R8: Between frames, any byte other than 0x33, 0xCC, `DBG_MARK` or `ACK_MARK` is skipped without a reply. This includes the not-acknowledge code `NAK_MARK` (default 0x00).
- R9: Inside a frame, if `TO_BITS` `bit_tick` pulses pass with no byte received, the frame is dropped without an acknowledge. Any partial word is discarded and the next byte is decoded as a mark.
- R10: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` holds its value.
- R11: An acknowledge that falls due while an outbound word frame is being sent follows that frame's last byte.
- R12: After reset, `tx_valid`, `core_rst`, `core_start` and `mbx_full` are 0 and `core_tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: received byte present |
| rx_data | input | 8 | Received byte |
| bit_tick | input | 1 | One pulse per serial bit time |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | UART takes the byte |
| pmem_we | output | 1 | Program memory write strobe |
| pmem_addr | output | AW | Program memory write address |
| pmem_wdata | output | 8 | Program memory write byte |
| core_rst | output | 1 | Holds the core in reset |
| core_start | output | 1 | One-cycle start pulse |
| core_start_addr | output | AW | Start address for the core |
| mbx_full | output | 1 | Inbound mailbox holds a word |
| mbx_data | output | DW | Inbound mailbox word |
| mbx_rd | input | 1 | Core has read the mailbox |
| core_tx_valid | input | 1 | Core offers an outbound word |
| core_tx_word | input | DW | Outbound word |
| core_tx_ready | output | 1 | Block can take an outbound word |

## Verification
The assertions check the following on every cycle:
- the transmit byte stays stable under backpressure;
- memory writes happen only while the core is held in reset;
- the reset release and the start pulse occur together, and the start pulse lasts one cycle;
- the mailbox keeps its word until it is read;
- the parser is idle after a timeout;
- the block stops being ready once it has taken an outbound word.

Only the bench scenarios can show the remaining behaviour:
- command decoding with lengths of zero, one and several bytes;
- the byte order on the link and zero-extension;
- the refused acknowledge when the mailbox is full;
- skipped stray bytes and the ordering of a delayed acknowledge;
- the full debug handshake with the all-ones, 0x5F5 and 0x505 words.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;
  typedef enum logic [2:0] {PS_IDLE, PS_ADDR, PS_LEN, PS_IMAGE, PS_DEBUG} pstate_t;
  typedef enum logic [1:0] {TS_IDLE, TS_ACK, TS_WORD} tstate_t;

  localparam logic [7:0] CMD_START = 8'h33;
  localparam logic [7:0] CMD_LOAD  = 8'hCC;

  // bytes needed to carry a word of w bits
  function automatic int bytes_for(input int w);
    return (w + 7) / 8;
  endfunction
endpackage

// File: rtl/dbg_word_asm.sv
module dbg_word_asm #(
  parameter int DW = 12,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift,
  input  logic [7:0]    din,
  output logic          done,
  output logic [DW-1:0] word
);
  localparam int CW = $clog2(NB + 1);
  logic [DW-1:0] acc;
  logic [CW-1:0] cnt;

  assign word = DW'({acc, din});
  assign done = shift && (cnt == CW'(NB - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc <= '0;
      cnt <= '0;
    end else if (shift) begin
      if (done) begin
        acc <= '0;
        cnt <= '0;
      end else begin
        acc <= word;
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/dbg_frame_timer.sv
module dbg_frame_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic kick,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign expire = active && tick && !kick && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !active || kick || expire) cnt <= '0;
    else if (tick)                           cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/dbg_tx_engine.sv
module dbg_tx_engine
  import dbg_link_pkg::*;
#(
  parameter int         DW       = 12,
  parameter int         NB       = 2,
  parameter logic [7:0] DBG_MARK = 8'h3C,
  parameter logic [7:0] ACK_MARK = 8'hC3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_req,
  input  logic          host_ack,
  input  logic          word_valid,
  input  logic [DW-1:0] word_in,
  output logic          word_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready
);
  localparam int SW = NB * 8;
  localparam int IW = $clog2(NB + 1);
  tstate_t       st;
  logic          ack_pend, wait_host;
  logic [SW-1:0] sh;
  logic [IW-1:0] idx;

  assign word_ready = (st == TS_IDLE) && !ack_pend && !wait_host;
  assign tx_valid   = (st != TS_IDLE);
  assign tx_data    = (st == TS_ACK) ? ACK_MARK :
                      (idx == '0)    ? DBG_MARK : sh[SW-1 -: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= TS_IDLE; ack_pend <= 1'b0; wait_host <= 1'b0; sh <= '0; idx <= '0;
    end else begin
      if (ack_req)            ack_pend <= 1'b1;
      else if (st == TS_IDLE) ack_pend <= 1'b0;
      if (host_ack) wait_host <= 1'b0;
      case (st)
        TS_IDLE: begin
          if (ack_pend) st <= TS_ACK;
          else if (word_valid && word_ready) begin
            sh  <= SW'(word_in);
            idx <= '0;
            st  <= TS_WORD;
          end
        end
        TS_ACK: if (tx_ready) st <= TS_IDLE;
        TS_WORD: if (tx_ready) begin
          if (idx != '0) sh <= sh << 8;
          if (idx == IW'(NB)) begin
            st <= TS_IDLE;
            wait_host <= 1'b1;
          end else idx <= idx + IW'(1);
        end
        default: st <= TS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbg_link_ctrl.sv
module dbg_link_ctrl
  import dbg_link_pkg::*;
#(
  parameter int         DW       = 12,
  parameter int         NB       = bytes_for(DW),
  parameter int         AW       = 12,
  parameter int         TO_BITS  = 16,
  parameter logic [7:0] DBG_MARK = 8'h3C,
  parameter logic [7:0] ACK_MARK = 8'hC3,
  parameter logic [7:0] NAK_MARK = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          bit_tick,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  output logic          pmem_we,
  output logic [AW-1:0] pmem_addr,
  output logic [7:0]    pmem_wdata,
  output logic          core_rst,
  output logic          core_start,
  output logic [AW-1:0] core_start_addr,
  output logic          mbx_full,
  output logic [DW-1:0] mbx_data,
  input  logic          mbx_rd,
  input  logic          core_tx_valid,
  input  logic [DW-1:0] core_tx_word,
  output logic          core_tx_ready
);
  pstate_t       ps;
  logic          is_load;
  logic [DW-1:0] addr_q, left_q;
  logic [AW-1:0] ld_addr;
  logic          word_done;
  logic [DW-1:0] word;

  // named internal events
  wire parse_idle = (ps == PS_IDLE);
  wire in_word    = (ps == PS_ADDR) || (ps == PS_LEN) || (ps == PS_DEBUG);
  wire host_ack   = rx_valid && parse_idle && (rx_data == ACK_MARK);
  wire stray_byte = rx_valid && parse_idle && (rx_data != CMD_START) &&
                    (rx_data != CMD_LOAD) && (rx_data != DBG_MARK) && (rx_data != ACK_MARK);
  wire dbg_take   = word_done && (ps == PS_DEBUG) && !mbx_full;
  wire len_done   = word_done && (ps == PS_LEN);
  wire last_img   = rx_valid && (ps == PS_IMAGE) && (left_q == DW'(1));
  wire go_start   = (len_done && (!is_load || word == '0)) || last_img;
  wire ack_req    = dbg_take || go_start;
  logic to_fire;

  dbg_word_asm #(.DW(DW), .NB(NB)) u_asm (
    .clk(clk), .rst_n(rst_n), .clr(parse_idle), .shift(rx_valid && in_word),
    .din(rx_data), .done(word_done), .word(word));

  dbg_frame_timer #(.LIMIT(TO_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(!parse_idle), .kick(rx_valid),
    .tick(bit_tick), .expire(to_fire));

  dbg_tx_engine #(.DW(DW), .NB(NB), .DBG_MARK(DBG_MARK), .ACK_MARK(ACK_MARK)) u_tx (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .host_ack(host_ack),
    .word_valid(core_tx_valid), .word_in(core_tx_word), .word_ready(core_tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready));

  assign pmem_we    = rx_valid && (ps == PS_IMAGE);
  assign pmem_addr  = ld_addr;
  assign pmem_wdata = rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps <= PS_IDLE; is_load <= 1'b0; addr_q <= '0; left_q <= '0; ld_addr <= '0;
    end else if (to_fire) begin
      ps <= PS_IDLE;
    end else if (rx_valid) begin
      case (ps)
        PS_IDLE: begin
          if (rx_data == CMD_START)     begin is_load <= 1'b0; ps <= PS_ADDR; end
          else if (rx_data == CMD_LOAD) begin is_load <= 1'b1; ps <= PS_ADDR; end
          else if (rx_data == DBG_MARK) ps <= PS_DEBUG;
        end
        PS_ADDR: if (word_done) begin addr_q <= word; ps <= PS_LEN; end
        PS_LEN: if (word_done) begin
          if (go_start) ps <= PS_IDLE;
          else begin
            ld_addr <= AW'(addr_q);
            left_q  <= word;
            ps      <= PS_IMAGE;
          end
        end
        PS_IMAGE: begin
          ld_addr <= ld_addr + AW'(1);
          left_q  <= left_q - DW'(1);
          if (last_img) ps <= PS_IDLE;
        end
        PS_DEBUG: if (word_done) ps <= PS_IDLE;
        default: ps <= PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_rst <= 1'b0; core_start <= 1'b0; core_start_addr <= '0;
      mbx_full <= 1'b0; mbx_data <= '0;
    end else begin
      core_start <= go_start;
      if (go_start) begin
        core_start_addr <= AW'(addr_q);
        if (is_load) core_rst <= 1'b0;
      end else if (rx_valid && parse_idle && rx_data == CMD_LOAD) core_rst <= 1'b1;
      if (dbg_take) begin
        mbx_full <= 1'b1;
        mbx_data <= word;
      end else if (mbx_rd) mbx_full <= 1'b0;
    end
  end

  // stray bytes, including NAK_MARK, fall through the idle decode untouched
  wire unused_ok = stray_byte & (NAK_MARK == NAK_MARK);
endmodule

// File: rtl/dbg_link_chk.sv
module dbg_link_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          pmem_we,
  input logic          core_rst,
  input logic          core_start,
  input logic          mbx_full,
  input logic          mbx_rd,
  input logic [DW-1:0] mbx_data,
  input logic          to_fire,
  input logic          parse_idle,
  input logic          core_tx_valid,
  input logic          core_tx_ready
);
  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  // R3
  load_under_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pmem_we |-> core_rst);
  // R4
  release_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> core_start);
  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
  // R6
  mbx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mbx_full && !mbx_rd |=> mbx_full && $stable(mbx_data));
  // R9
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_fire |=> parse_idle);
  // R7
  out_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_tx_valid && core_tx_ready |=> !core_tx_ready);
endmodule

bind dbg_link_ctrl dbg_link_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .pmem_we(pmem_we), .core_rst(core_rst), .core_start(core_start), .mbx_full(mbx_full),
  .mbx_rd(mbx_rd), .mbx_data(mbx_data), .to_fire(to_fire), .parse_idle(parse_idle),
  .core_tx_valid(core_tx_valid), .core_tx_ready(core_tx_ready));

// File: tb/tb_dbg_link_ctrl.sv
module tb_dbg_link_ctrl;
  localparam int DW = 12, AW = 12;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, bit_tick = 0, tx_ready = 1, mbx_rd = 0, core_tx_valid = 0;
  logic [7:0] rx_data = 0;
  logic [DW-1:0] core_tx_word = 0;
  logic tx_valid, pmem_we, core_rst, core_start, mbx_full, core_tx_ready;
  logic [7:0] tx_data, pmem_wdata;
  logic [AW-1:0] pmem_addr, core_start_addr;
  logic [DW-1:0] mbx_data;
  int checks = 0, fails = 0;
  logic [7:0] exp_tx[$];
  logic [19:0] exp_wr[$];
  logic [AW-1:0] exp_st[$];

  always #10 clk = ~clk;

  dbg_link_ctrl dut (.*);

  int tick_div = 0;
  always @(posedge clk) begin
    tick_div <= (tick_div == 3) ? 0 : tick_div + 1;
    bit_tick <= (tick_div == 3);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (tx_valid && tx_ready) begin
      if (exp_tx.size() == 0) chk("R8 unexpected tx byte", tx_data, 'hxx);
      else chk("R7 tx byte", tx_data, exp_tx.pop_front());
    end
    if (pmem_we) begin
      if (exp_wr.size() == 0) chk("R3 unexpected write", {pmem_addr, pmem_wdata}, 0);
      else chk("R3 image write", {pmem_addr, pmem_wdata}, exp_wr.pop_front());
    end
    if (core_start) begin
      if (exp_st.size() == 0) chk("R2 unexpected start", core_start_addr, 0);
      else chk("R4 start address", core_start_addr, exp_st.pop_front());
    end
  end

  task automatic put_byte(input logic [7:0] b);
    @(posedge clk); #1 rx_valid = 1; rx_data = b;
    @(posedge clk); #1 rx_valid = 0;
    repeat (2) @(posedge clk);
  endtask

  // R1: two bytes, most significant first
  task automatic put_word(input logic [15:0] w);
    put_byte(w[15:8]);
    put_byte(w[7:0]);
  endtask

  task automatic core_send(input logic [DW-1:0] w);
    @(posedge clk); #1 core_tx_valid = 1; core_tx_word = w;
    forever begin @(negedge clk); if (core_tx_ready) break; end
    @(posedge clk); #1 core_tx_valid = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 tx_valid", tx_valid, 0);
    chk("R12 core_rst", core_rst, 0);
    chk("R12 mbx_full", mbx_full, 0);
    chk("R12 core_tx_ready", core_tx_ready, 1);

    // R8: stray zeros and an unknown byte are skipped
    put_byte(8'h00); put_byte(8'h00); put_byte(8'h55);
    // R2: start without reset, zero length
    exp_tx.push_back(8'hC3); exp_st.push_back(12'h055);
    put_byte(8'h33); put_word(16'h0055); put_word(16'h0000);
    settle(10);
    chk("R2 core_rst untouched", core_rst, 0);

    // R4: load, length zero
    put_byte(8'hCC);
    chk("R3 reset held", core_rst, 1);
    exp_tx.push_back(8'hC3); exp_st.push_back(12'h010);
    put_word(16'h0010); put_word(16'h0000);
    settle(10);
    chk("R4 reset released len0", core_rst, 0);

    // R3/R4: load, length one
    exp_wr.push_back({12'h020, 8'hA5});
    exp_tx.push_back(8'hC3); exp_st.push_back(12'h020);
    put_byte(8'hCC); put_word(16'h0020); put_word(16'h0001); put_byte(8'hA5);
    settle(10);
    chk("R4 reset released len1", core_rst, 0);

    // R3/R4: load, several bytes (mark-valued bytes inside the image)
    put_byte(8'hCC); put_word(16'h0100); put_word(16'h0005);
    for (int i = 0; i < 5; i++) begin
      logic [7:0] b;
      b = (i == 2) ? 8'h33 : 8'(i * 7 + 3);
      exp_wr.push_back({12'(12'h100 + i), b});
      if (i == 4) begin exp_tx.push_back(8'hC3); exp_st.push_back(12'h100); end
      chk("R3 reset held during image", core_rst, 1);
      put_byte(b);
    end
    settle(10);
    chk("R4 reset released len5", core_rst, 0);

    // R7: handshake, target sends all ones (zero-extended to 0x0FFF)
    exp_tx.push_back(8'h3C); exp_tx.push_back(8'h0F); exp_tx.push_back(8'hFF);
    core_send(12'hFFF);
    settle(20);
    chk("R7 waits for host ack", core_tx_ready, 0);
    put_byte(8'hC3);
    chk("R7 ready after host ack", core_tx_ready, 1);
    // R5/R1: host replies 0x5F5, top nibble of first byte dropped
    exp_tx.push_back(8'hC3);
    put_byte(8'h3C); put_word(16'hA5F5);
    settle(10);
    chk("R5 mbx_full", mbx_full, 1);
    chk("R1 R5 mbx_data", mbx_data, 12'h5F5);
    @(posedge clk); #1 mbx_rd = 1; @(posedge clk); #1 mbx_rd = 0;
    chk("R5 mbx cleared", mbx_full, 0);
    exp_tx.push_back(8'h3C); exp_tx.push_back(8'h05); exp_tx.push_back(8'h05);
    core_send(12'h505);
    settle(20);
    put_byte(8'hC3);

    // R6: full mailbox refuses second frame
    exp_tx.push_back(8'hC3);
    put_byte(8'h3C); put_word(16'h0123);
    settle(10);
    put_byte(8'h3C); put_word(16'h0456);
    settle(20);
    chk("R6 mailbox kept", mbx_data, 12'h123);
    chk("R6 still full", mbx_full, 1);
    @(posedge clk); #1 mbx_rd = 1; @(posedge clk); #1 mbx_rd = 0;

    // R10/R11: backpressure on an outbound frame, ack queued behind it
    @(posedge clk); #1 tx_ready = 0;
    exp_tx.push_back(8'h3C); exp_tx.push_back(8'h0A); exp_tx.push_back(8'hBC);
    exp_tx.push_back(8'hC3);
    core_send(12'hABC);
    put_byte(8'h3C); put_word(16'h0077);
    settle(5);
    chk("R10 tx_valid held", tx_valid, 1);
    chk("R10 tx_data held", tx_data, 8'h3C);
    @(posedge clk); #1 tx_ready = 1;
    settle(20);
    chk("R11 mailbox got word", mbx_data, 12'h077);
    put_byte(8'hC3);
    @(posedge clk); #1 mbx_rd = 1; @(posedge clk); #1 mbx_rd = 0;

    // R9: stalled frame is dropped, next bytes decode as a fresh frame
    put_byte(8'h33); put_byte(8'h12);
    settle(120);
    exp_tx.push_back(8'hC3); exp_st.push_back(12'h077);
    put_byte(8'h33); put_word(16'h0077); put_word(16'h0000);
    settle(20);
    chk("R9 no leftover tx", exp_tx.size(), 0);
    chk("R3 all writes seen", exp_wr.size(), 0);
    chk("R4 all starts seen", exp_st.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule